// File: doc/BRIEF.md
# Display tearing-effect request sequencer

This block asks a display peripheral on a serial link to report its tearing-effect (TE) event. It hands single-cycle bus-turnaround (BTA) requests to the link layer, then watches the link layer's strobes for a returned BTA and for a TE trigger. Once the TE has been seen, the request is finished. The block then pulses `done_o` and returns to idle. A request can also end in an error, or through an external force stop.

There are two modes, and the mode is latched when a request is accepted. In automatic mode the block issues at most two BTAs and then waits for a TE. The wait is bounded by a programmable window that is counted in byte-clock cycles. In polling mode the block keeps issuing BTAs until one response carries a TE. No window applies in this mode, and only a force stop ends a loop that gets no answer. Two sticky error flags report a missing TE and a window timeout.

Top module: `te_req_seq`

## Requirements
- R1: A start pulse in idle is accepted only when `bta_en_i` and `te_en_i` are both 1. If either is 0, the start is ignored: `busy_o` stays 0 and no BTA is requested. After an accepted start, `busy_o` is 1 from the next cycle until the block returns to idle.
- R2: With `poll_mode_i`=0, the first BTA response is checked for a TE. If that response, and the time while it was awaited, carried no TE, a second BTA is issued.
- R3: With `poll_mode_i`=0, a TE seen while the first BTA is outstanding, or together with its response, finishes the request after one BTA with no error flag.
- R4: With `poll_mode_i`=0, a second response without a TE makes the block wait for a TE strobe. A TE with the second response, or a TE during that wait, finishes the request with no error flag.
- R5: `timeout_cfg_i[11:10]` selects a shift of 8, 9, 10 or 11, giving the window N = `timeout_cfg_i[9:0]` × 256, 512, 1024 or 2048 cycles. The window starts on the cycle of the first BTA strobe and restarts on the second. If the awaited event has not come, the request ends with `done_o` high exactly N+2 cycles after the cycle of the latest BTA strobe. A value of 0 in bits 9:0 ends the request 2 cycles after the strobe.
- R6: If the window expires while a BTA response is still outstanding, or while the second BTA is waiting for the link, `err_timeout_o` is set. If it expires while the block waits for a TE after the second response, `err_no_te_o` is set.
- R7: With `poll_mode_i`=1, each response without a TE brings another BTA. The first response that carries a TE finishes the request, so k responses without a TE give k+1 BTAs. No window runs in this mode, and `err_no_te_o` is never set.
- R8: `force_stop_i` high while busy holds `bta_req_o` at 0 in that cycle. The next cycle shows `busy_o`=0 and `done_o`=1, and neither error flag changes.
- R9: `bta_req_o` is a single-cycle pulse. It is high only while `link_rdy_i` is 1, and never while the previous BTA's response is still outstanding.
- R10: Error flags stay set until a `clr_err_i` pulse, or until a start is accepted. Either one clears them from the following cycle.
- R11: `done_o` is a one-cycle pulse that appears in the first idle cycle after a request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a TE sequence |
| force_stop_i | input | 1 | Abort the running sequence |
| clr_err_i | input | 1 | Clear the sticky error flags |
| poll_mode_i | input | 1 | 1 = polling mode, 0 = automatic mode |
| bta_en_i | input | 1 | BTA enable |
| te_en_i | input | 1 | TE request enable |
| timeout_cfg_i | input | 12 | Window field: [11:10] shift select, [9:0] base count |
| link_rdy_i | input | 1 | Link layer can accept a BTA request |
| bta_rcvd_i | input | 1 | Strobe: BTA returned by the peripheral |
| te_rcvd_i | input | 1 | Strobe: TE trigger received |
| bta_req_o | output | 1 | Single-cycle BTA request |
| done_o | output | 1 | Sequence finished pulse |
| busy_o | output | 1 | Sequence in progress |
| err_no_te_o | output | 1 | Sticky: no TE after the second BTA |
| err_timeout_o | output | 1 | Sticky: window expired awaiting a BTA response |

## Verification
The assertions assume the link layer gives at most one `bta_rcvd_i` strobe per requested BTA, and only after that request. They also assume `timeout_cfg_i` stays unchanged while a window runs. The bench's peripheral model answers each strobe once, a set delay later, and never sends an unsolicited response. It changes the window field only between requests. `link_rdy_i` is toggled at random, while start, force stop and clear are driven only in the states the scenarios intend.

// File: rtl/te_seq_pkg.sv
package te_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT_BTA,
        ST_WAIT_TE
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       second;
        logic       poll;
        logic       te_seen;
        logic       done;
    } seq_regs_t;

    localparam int ERR_NO_TE   = 0;
    localparam int ERR_TIMEOUT = 1;
    localparam int ERR_COUNT   = 2;

endpackage

// File: rtl/te_win_timer.sv
module te_win_timer #(
    parameter int BASE_W    = 10,
    parameter int SEL_W     = 2,
    parameter int MIN_SHIFT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    stop_i,
    input  logic [BASE_W+SEL_W-1:0] cfg_i,
    output logic                    expired_o
);
    localparam int CNT_W = BASE_W + MIN_SHIFT + (1 << SEL_W) - 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             d, q;
    logic [CNT_W-1:0] span;

    always_comb begin
        span = CNT_W'(cfg_i[BASE_W-1:0]) << (MIN_SHIFT + int'(cfg_i[BASE_W +: SEL_W]));
        d    = q;
        if (stop_i) begin
            d.run = 1'b0;
        end else if (load_i) begin
            d.run = 1'b1;
            d.cnt = span;
        end else if (q.run && q.cnt != '0) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired_o = q.run && (q.cnt == '0);

    assert_window_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.cnt != '0 && !load_i && !stop_i) |=> (q.cnt == $past(q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/te_sticky_flags.sv
module te_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            if (set_i[i])     flags_d[i] = 1'b1;
            else if (clr_i)   flags_d[i] = 1'b0;
            else              flags_d[i] = flags_q[i];
        end

        assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_i) |=> flags_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/te_req_seq.sv
module te_req_seq
    import te_seq_pkg::*;
#(
    parameter int BASE_W    = 10,
    parameter int SEL_W     = 2,
    parameter int MIN_SHIFT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    force_stop_i,
    input  logic                    clr_err_i,
    input  logic                    poll_mode_i,
    input  logic                    bta_en_i,
    input  logic                    te_en_i,
    input  logic [BASE_W+SEL_W-1:0] timeout_cfg_i,
    input  logic                    link_rdy_i,
    input  logic                    bta_rcvd_i,
    input  logic                    te_rcvd_i,
    output logic                    bta_req_o,
    output logic                    done_o,
    output logic                    busy_o,
    output logic                    err_no_te_o,
    output logic                    err_timeout_o
);
    seq_regs_t            d, q;
    logic                 tmr_load, tmr_stop, tmr_exp;
    logic                 err_clr;
    logic [ERR_COUNT-1:0] err_set, err_flags;
    logic                 te_now;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        bta_req_o = 1'b0;
        tmr_load  = 1'b0;
        tmr_stop  = 1'b0;
        err_set   = '0;
        err_clr   = clr_err_i;
        te_now    = q.te_seen || te_rcvd_i;

        case (q.st)
            ST_IDLE: begin
                if (start_i && bta_en_i && te_en_i) begin
                    d.st      = ST_SEND;
                    d.second  = 1'b0;
                    d.poll    = poll_mode_i;
                    d.te_seen = 1'b0;
                    err_clr   = 1'b1;
                end
            end
            ST_SEND: begin
                if (link_rdy_i && !force_stop_i) begin
                    bta_req_o = 1'b1;
                    tmr_load  = !q.poll;
                    d.st      = ST_WAIT_BTA;
                    d.te_seen = te_rcvd_i;
                end else if (tmr_exp) begin
                    err_set[ERR_TIMEOUT] = 1'b1;
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    tmr_stop = 1'b1;
                end
            end
            ST_WAIT_BTA: begin
                if (te_rcvd_i) d.te_seen = 1'b1;
                if (bta_rcvd_i) begin
                    if (te_now) begin
                        d.st     = ST_IDLE;
                        d.done   = 1'b1;
                        tmr_stop = 1'b1;
                    end else if (q.poll) begin
                        d.st      = ST_SEND;
                        d.te_seen = 1'b0;
                    end else if (!q.second) begin
                        d.st      = ST_SEND;
                        d.second  = 1'b1;
                        d.te_seen = 1'b0;
                    end else begin
                        d.st = ST_WAIT_TE;
                    end
                end else if (tmr_exp) begin
                    err_set[ERR_TIMEOUT] = 1'b1;
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    tmr_stop = 1'b1;
                end
            end
            ST_WAIT_TE: begin
                if (te_rcvd_i) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    tmr_stop = 1'b1;
                end else if (tmr_exp) begin
                    err_set[ERR_NO_TE] = 1'b1;
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    tmr_stop = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (force_stop_i && q.st != ST_IDLE) begin
            d.st     = ST_IDLE;
            d.done   = 1'b1;
            tmr_load = 1'b0;
            tmr_stop = 1'b1;
            err_set  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    te_win_timer #(
        .BASE_W    (BASE_W),
        .SEL_W     (SEL_W),
        .MIN_SHIFT (MIN_SHIFT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .stop_i    (tmr_stop),
        .cfg_i     (timeout_cfg_i),
        .expired_o (tmr_exp)
    );

    te_sticky_flags #(
        .N (ERR_COUNT)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (err_set),
        .clr_i   (err_clr),
        .flags_o (err_flags)
    );

    assign done_o        = q.done;
    assign busy_o        = (q.st != ST_IDLE);
    assign err_no_te_o   = err_flags[ERR_NO_TE];
    assign err_timeout_o = err_flags[ERR_TIMEOUT];

    // Outstanding-response tracker kept only for the checks below.
    logic outst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           outst_q <= 1'b0;
        else if (bta_req_o)                   outst_q <= 1'b1;
        else if (bta_rcvd_i || !busy_o)       outst_q <= 1'b0;
    end

    assert_bta_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bta_req_o |-> link_rdy_i);
    assert_bta_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bta_req_o |=> !bta_req_o);
    assert_bta_after_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bta_req_o |-> !outst_q);
    assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !(bta_en_i && te_en_i)) |=> !busy_o);
    assert_force_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stop_i && busy_o) |=> (!busy_o && done_o && $stable(err_no_te_o) && $stable(err_timeout_o)));
    assert_poll_no_te_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_no_te_o) |-> !q.poll);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/te_req_seq_tb.sv
module te_req_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 0, force_stop = 0, clr_err = 0, poll_mode = 0;
    logic        bta_en = 1, te_en = 1, link_rdy = 0, bta_rcvd = 0, te_rcvd = 0;
    logic [11:0] cfg = 12'd0;
    logic        bta_req, done, busy, err_nte, err_to;

    int n_tests = 0, n_fail = 0, cidx = 0;
    bit pend = 0, finished = 0;
    bit s_req, s_done, s_busy, s_nte, s_to;

    always #5 clk = ~clk;

    te_req_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .force_stop_i(force_stop),
        .clr_err_i(clr_err), .poll_mode_i(poll_mode), .bta_en_i(bta_en), .te_en_i(te_en),
        .timeout_cfg_i(cfg), .link_rdy_i(link_rdy), .bta_rcvd_i(bta_rcvd), .te_rcvd_i(te_rcvd),
        .bta_req_o(bta_req), .done_o(done), .busy_o(busy),
        .err_no_te_o(err_nte), .err_timeout_o(err_to)
    );

    function automatic int span(input logic [11:0] c);
        return int'(c[9:0]) << (8 + int'(c[11:10]));
    endfunction

    function automatic int exp_bta(input bit poll, input int n_plain);
        if (poll) return n_plain + 1;
        return (n_plain >= 1) ? 2 : 1;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, expv);
        end
    endtask

    // Inputs are set at a negedge; sample 1 ns later, then move to the next negedge.
    task automatic cyc();
        #1;
        s_req = bta_req; s_done = done; s_busy = busy; s_nte = err_nte; s_to = err_to;
        if (s_req) begin
            chk(link_rdy == 1'b1, "R9", "bta_req without link_rdy", 0, 1);
            chk(!pend, "R9", "bta_req while response outstanding", 1, 0);
        end
        @(negedge clk);
        cidx++;
    endtask

    task automatic req(input bit poll, input int n_plain, input bit te_late, input bit answer,
                       input int dly, input int stop_after, input int maxc,
                       output int nb, output int l_first, output int l_last, output int d_at);
        int resp_at, te_at, cur;
        nb = 0; l_first = -1; l_last = -1; d_at = -1; resp_at = -1; te_at = -1; pend = 0;
        poll_mode = poll; start = 1; link_rdy = 0;
        cyc();
        start = 0;
        cyc();
        chk(s_busy, "R1", "busy after accepted start", int'(s_busy), 1);
        chk(!s_nte && !s_to, "R10", "flags cleared by start", int'(s_nte) + int'(s_to), 0);
        for (int i = 0; i < maxc; i++) begin
            cur = cidx;
            link_rdy = ($urandom_range(3) != 0);
            bta_rcvd = 0; te_rcvd = 0;
            if (answer && resp_at == cur) begin
                bta_rcvd = 1;
                te_rcvd  = (nb > n_plain);
                pend     = 0;
                if (te_late && !poll && nb == 2 && !te_rcvd) te_at = cur + dly;
            end
            if (te_at == cur) te_rcvd = 1;
            cyc();
            if (s_req) begin
                nb++; pend = 1; resp_at = cur + dly;
                if (l_first < 0) l_first = cur;
                l_last = cur;
            end
            if (s_done) begin d_at = cur; break; end
            if (stop_after > 0 && nb >= stop_after) break;
        end
        bta_rcvd = 0; te_rcvd = 0; link_rdy = 0;
        if (d_at >= 0) begin
            cyc();
            chk(!s_done && !s_busy, "R11", "done is a single idle pulse", int'(s_done) + int'(s_busy), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int nb, lf, ll, da, n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        chk(!s_busy && !s_done && !s_req && !s_nte && !s_to, "R11", "reset state", int'(s_busy), 0);

        // R1: enables gate the start.
        bta_en = 0; start = 1; link_rdy = 1; cyc(); start = 0;
        repeat (4) begin cyc(); chk(!s_busy && !s_req, "R1", "start ignored, bta_en=0", int'(s_busy), 0); end
        bta_en = 1; te_en = 0; start = 1; cyc(); start = 0;
        repeat (4) begin cyc(); chk(!s_busy && !s_req, "R1", "start ignored, te_en=0", int'(s_busy), 0); end
        te_en = 1; link_rdy = 0;

        // R3: TE with the first response finishes after one BTA.
        cfg = {2'b00, 10'd200};
        req(0, 0, 0, 1, 4, 0, 500, nb, lf, ll, da);
        chk(nb == 1 && da >= 0, "R3", "BTA count, TE on first", nb, 1);
        chk(!s_nte && !s_to, "R3", "no error", int'(s_nte) + int'(s_to), 0);
        // R2: plain first response -> second BTA, TE with second response (R4).
        req(0, 1, 0, 1, 5, 0, 500, nb, lf, ll, da);
        chk(nb == 2 && da >= 0, "R2", "second BTA issued", nb, 2);
        // R4: both plain, TE arrives later while waiting.
        req(0, 2, 1, 1, 6, 0, 500, nb, lf, ll, da);
        chk(nb == 2 && da >= 0 && !s_nte && !s_to, "R4", "late TE accepted", nb, 2);

        // R7 and random mix.
        for (int k = 0; k < 30; k++) begin
            bit p; int np, dl;
            p  = $urandom_range(1);
            np = p ? $urandom_range(5) : $urandom_range(1);
            dl = $urandom_range(8, 1);
            req(p, np, 0, 1, dl, 0, 800, nb, lf, ll, da);
            chk(nb == exp_bta(p, np) && da >= 0, p ? "R7" : "R2", "random BTA count", nb, exp_bta(p, np));
            chk(!s_nte && !s_to, p ? "R7" : "R3", "random no error", int'(s_nte) + int'(s_to), 0);
        end

        // R5/R6: unanswered BTA times out N+2 cycles after the strobe.
        cfg = {2'b01, 10'd3};
        req(0, 0, 0, 0, 1, 0, 3000, nb, lf, ll, da);
        chk(da == ll + span(cfg) + 2, "R5", "timeout instant x512", da - ll, span(cfg) + 2);
        chk(s_to && !s_nte, "R6", "timeout flag", int'(s_to), 1);
        // R10: sticky through idle, cleared by clr_err.
        repeat (10) cyc();
        chk(s_to, "R10", "flag sticky in idle", int'(s_to), 1);
        clr_err = 1; cyc(); clr_err = 0; cyc();
        chk(!s_to, "R10", "clr_err clears", int'(s_to), 0);

        cfg = {2'b11, 10'd2};
        req(0, 0, 0, 0, 1, 0, 6000, nb, lf, ll, da);
        chk(da == ll + span(cfg) + 2, "R5", "timeout instant x2048", da - ll, span(cfg) + 2);
        cfg = {2'b10, 10'd0};
        req(0, 0, 0, 0, 1, 0, 50, nb, lf, ll, da);
        chk(da == ll + 2 && s_to, "R5", "zero window immediate", da - ll, 2);

        // R6: no TE after second BTA; window restarts at second BTA.
        cfg = {2'b00, 10'd1};
        req(0, 2, 0, 1, 200, 0, 2000, nb, lf, ll, da);
        chk(nb == 2 && da == ll + span(cfg) + 2, "R5", "window restarted at second BTA", da - ll, span(cfg) + 2);
        chk(da - lf > span(cfg) + 2, "R5", "not counted from first BTA", da - lf, span(cfg) + 3);
        chk(s_nte && !s_to, "R6", "no-TE flag", int'(s_nte), 1);

        // R8: force stop ends an unanswered polling loop.
        cfg = {2'b00, 10'd1};
        req(1, 1000, 0, 1, 3, 4, 2000, nb, lf, ll, da);
        force_stop = 1; link_rdy = 1; cyc();
        chk(!s_req, "R8", "no BTA during force stop", int'(s_req), 0);
        force_stop = 0; link_rdy = 0; cyc();
        chk(!s_busy && s_done && !s_nte && !s_to, "R8", "idle+done, no error", int'(s_busy), 0);
        chk(nb == 4, "R7", "polling kept issuing BTAs", nb, 4);
        repeat (3) cyc();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule